// File: doc/BRIEF.md
# Remote Reconfiguration Control Registers

This block is a small Wishbone slave that a soft processor uses to prepare and launch a reload of the FPGA from another page of the external configuration flash. Software writes a boot page address, a watchdog start value and a watchdog enable into a pending bank. It then writes the go bit of the control register. The block copies the pending bank into the current bank and moves the old current bank into the previous bank. At the same time it emits a one-cycle reconfiguration request that carries the byte address to load from.

A 2-bit read-source code in the control register picks which bank a read returns: current, previous or pending. The boot page is held word-shifted, so only address bits 24 down to 2 are stored. The watchdog value supplies only the upper bits of a wider countdown counter, and the lower bits are zero. The watchdog arms only at a reconfiguration, and only if enable was set at that moment. A kick input from the newly loaded image reloads the counter, and so does any register write. If the counter runs out, the block issues a fallback request to the factory page at address 0.

The controller clock must stay below 40 MHz. The `CLK_HZ` parameter records the clock rate, and elaboration stops with an error if it is 40 MHz or more.

Top module: `rcfg_ctrl`

## Requirements
- R1: After reset all three banks are zero, the read-source code is 00 and `reconf_req` is low, so every register reads 0.
- R2: Each Wishbone cycle is acknowledged for exactly one clock, in the cycle after the strobe is seen. Read data is valid together with the acknowledge.
- R3: Register word 0 (byte offset 0x0) holds the boot page as a word address in bits BOOT_W-1:0. A request carries that value shifted left by 2 as a byte address, so a stored 0x20000 requests byte address 0x80000.
- R4: The control register (word 3) keeps the read-source code in bits 5:4, and that code selects the bank for reads of words 0 to 2. Code 00 selects current, 01 selects previous, 11 selects pending, and 10 reads as zero. Word 1 is the watchdog value and word 2 bit 0 is the enable. Reading the control register returns the read-source code in bits 5:4 and 0 elsewhere.
- R5: Writes to words 0, 1 and 2 change the pending bank only while the stored read-source code is 00. Otherwise they are ignored.
- R6: Writing 1 to control bit 0 starts a reconfiguration, whatever read-source code is written with it. `reconf_req` is high for one clock, in the same cycle as the acknowledge. The pending bank becomes current and the old current bank becomes previous. Bit 0 always reads 0.
- R7: When a reconfiguration arms the watchdog, the start value is S = field << (WD_W - WD_HI_W). Without a kick or a write, `reconf_req` rises again S+1 clocks after the launching request, with `reconf_addr` = 0. This fallback moves current to previous and sets the current boot page and the current enable to 0.
- R8: The enable arms or disarms the watchdog only at a go-bit reconfiguration. Writing enable alone never causes a request, and a reconfiguration with enable 0 is never followed by a fallback.
- R9: While armed, a `wd_kick` pulse or any accepted register write reloads the counter to S. The fallback then follows S+1 clocks after the reloading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| wb_cyc | input | 1 | Wishbone cycle |
| wb_stb | input | 1 | Wishbone strobe |
| wb_we | input | 1 | Wishbone write enable |
| wb_adr | input | 2 | Word address (byte address bits 3:2) |
| wb_dat_w | input | 32 | Write data |
| wb_dat_r | output | 32 | Read data, valid with acknowledge |
| wb_ack | output | 1 | Acknowledge |
| wd_kick | input | 1 | Watchdog reload from the running image |
| reconf_req | output | 1 | One-cycle reconfiguration request |
| reconf_addr | output | BOOT_W+2 | Byte address for the request |

## Verification
A wrong bank copy or a wrong read-source decode shows up at the read port on the next acknowledged read after the reconfiguration: a stale current, previous or pending value comes back. A wrong shift or a wrong field position shows up in `reconf_addr` in the same cycle as the acknowledge of the launching write. A wrong watchdog load, step or reload moves the fallback request away from the exact clock that S predicts, so errors of a single clock are caught. A wrong arming rule shows up as a request that appears or never comes during a long quiet window.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
  localparam int WB_DW = 32;

  typedef enum logic [1:0] {
    RS_CUR  = 2'b00,
    RS_PREV = 2'b01,
    RS_RSVD = 2'b10,
    RS_PEND = 2'b11
  } rsel_e;

  localparam logic [1:0] OFS_BOOT = 2'd0;
  localparam logic [1:0] OFS_WD   = 2'd1;
  localparam logic [1:0] OFS_EN   = 2'd2;
  localparam logic [1:0] OFS_CTL  = 2'd3;

  localparam int CTL_GO    = 0;
  localparam int CTL_RS_LO = 4;
endpackage

// File: rtl/rcfg_wb_port.sv
module rcfg_wb_port (
  input  logic       clk,
  input  logic       rst,
  input  logic       wb_cyc,
  input  logic       wb_stb,
  input  logic       wb_we,
  input  logic [1:0] wb_adr,
  output logic       wb_ack,
  output logic       wr_boot,
  output logic       wr_wd,
  output logic       wr_en,
  output logic       wr_ctl,
  output logic       any_wr,
  output logic       rd_stb
);
  import rcfg_pkg::*;

  logic accept;
  assign accept  = wb_cyc & wb_stb & ~wb_ack;
  assign any_wr  = accept & wb_we;
  assign rd_stb  = accept & ~wb_we;
  assign wr_boot = any_wr & (wb_adr == OFS_BOOT);
  assign wr_wd   = any_wr & (wb_adr == OFS_WD);
  assign wr_en   = any_wr & (wb_adr == OFS_EN);
  assign wr_ctl  = any_wr & (wb_adr == OFS_CTL);

  always_ff @(posedge clk) begin
    if (rst) wb_ack <= 1'b0;
    else     wb_ack <= accept;
  end

  // R2: acknowledge follows an accepted strobe by one clock
  a_r2_ack_next: assert property (@(posedge clk) disable iff (rst)
    accept |=> wb_ack);
  // R2: no acknowledge without a strobe in the previous clock
  a_r2_ack_cause: assert property (@(posedge clk) disable iff (rst)
    wb_ack |-> $past(wb_cyc && wb_stb));
endmodule

// File: rtl/rcfg_regs.sv
module rcfg_regs #(
  parameter int BOOT_W  = 23,
  parameter int WD_HI_W = 12,
  localparam int BYTE_W = BOOT_W + 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_boot,
  input  logic               wr_wd,
  input  logic               wr_en,
  input  logic               wr_ctl,
  input  logic               rd_stb,
  input  logic [1:0]         rd_sel,
  input  logic [31:0]        wdata,
  input  logic               expire,
  output logic               load,
  output logic [WD_HI_W-1:0] pend_wd,
  output logic               pend_en,
  output logic [31:0]        rdata,
  output logic               reconf_req,
  output logic [BYTE_W-1:0]  reconf_addr
);
  import rcfg_pkg::*;

  typedef struct packed {
    logic [BOOT_W-1:0]  boot;
    logic [WD_HI_W-1:0] wd;
    logic               en;
  } bank_t;

  bank_t pend, cur, prev, view;
  rsel_e rsel;
  logic  param_ok;
  logic [31:0] rd_word;
  logic unused_hi;

  function automatic logic [BYTE_W-1:0] page_to_byte(input logic [BOOT_W-1:0] page);
    return {page, 2'b00};
  endfunction

  assign unused_hi = ^wdata[31:BOOT_W];
  assign param_ok  = (rsel == RS_CUR);
  assign load      = wr_ctl & wdata[CTL_GO];
  assign pend_wd   = pend.wd;
  assign pend_en   = pend.en;

  always_comb begin
    case (rsel)
      RS_CUR:  view = cur;
      RS_PREV: view = prev;
      RS_PEND: view = pend;
      default: view = '0;
    endcase
    case (rd_sel)
      OFS_BOOT: rd_word = 32'(view.boot);
      OFS_WD:   rd_word = 32'(view.wd);
      OFS_EN:   rd_word = 32'(view.en);
      default:  rd_word = 32'(rsel) << CTL_RS_LO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend        <= '0;
      cur         <= '0;
      prev        <= '0;
      rsel        <= RS_CUR;
      rdata       <= '0;
      reconf_req  <= 1'b0;
      reconf_addr <= '0;
    end else begin
      reconf_req <= 1'b0;
      if (wr_boot && param_ok) pend.boot <= wdata[BOOT_W-1:0];
      if (wr_wd && param_ok)   pend.wd   <= wdata[WD_HI_W-1:0];
      if (wr_en && param_ok)   pend.en   <= wdata[0];
      if (wr_ctl)              rsel      <= rsel_e'(wdata[CTL_RS_LO +: 2]);
      if (load) begin
        prev        <= cur;
        cur         <= pend;
        reconf_req  <= 1'b1;
        reconf_addr <= page_to_byte(pend.boot);
      end else if (expire) begin
        prev        <= cur;
        cur.boot    <= '0;
        cur.en      <= 1'b0;
        reconf_req  <= 1'b1;
        reconf_addr <= '0;
      end
      if (rd_stb) rdata <= rd_word;
    end
  end

  // R5: parameter writes under a non-zero read source leave the pending page alone
  a_r5_ignore_boot: assert property (@(posedge clk) disable iff (rst)
    (wr_boot && rsel != RS_CUR) |=> $stable(pend.boot));
  // R6: the go bit raises the request with the pending page as byte address
  a_r6_launch: assert property (@(posedge clk) disable iff (rst)
    load |=> (reconf_req && reconf_addr[BYTE_W-1:2] == $past(pend.boot)
              && reconf_addr[1:0] == 2'b00));
  // R6: a request always has a launch or an expiry behind it
  a_r6_req_cause: assert property (@(posedge clk) disable iff (rst)
    reconf_req |-> $past(load || expire));
  // R7: an expiry falls back to the factory page
  a_r7_fallback: assert property (@(posedge clk) disable iff (rst)
    (expire && !load) |=> (reconf_req && reconf_addr == '0 && cur.boot == '0));
  // R4: the reserved read source returns zero
  a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && rsel == RS_RSVD && rd_sel != OFS_CTL) |=> rdata == '0);
endmodule

// File: rtl/rcfg_wdog.sv
module rcfg_wdog #(
  parameter int WD_W    = 29,
  parameter int WD_HI_W = 12,
  localparam int WD_LO_W = WD_W - WD_HI_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               en,
  input  logic [WD_HI_W-1:0] start_hi,
  input  logic               kick,
  output logic               expire
);
  logic [WD_W-1:0] cnt, start_q;
  logic            armed;

  function automatic logic [WD_W-1:0] wd_start(input logic [WD_HI_W-1:0] hi);
    return {hi, {WD_LO_W{1'b0}}};
  endfunction

  assign expire = armed & (cnt == '0) & ~load & ~kick;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      start_q <= '0;
      armed   <= 1'b0;
    end else if (load) begin
      armed   <= en;
      start_q <= wd_start(start_hi);
      cnt     <= wd_start(start_hi);
    end else if (armed) begin
      if (kick)             cnt   <= start_q;
      else if (cnt == '0)   armed <= 1'b0;
      else                  cnt   <= cnt - WD_W'(1);
    end
  end

  // R8: arming follows the enable sampled at the launch
  a_r8_arm_at_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (armed == $past(en)));
  // R9: a kick while armed restores the start value
  a_r9_reload: assert property (@(posedge clk) disable iff (rst)
    (kick && armed && !load) |=> (cnt == $past(start_q)));
  // R7: an armed counter steps down by one each clock
  a_r7_step: assert property (@(posedge clk) disable iff (rst)
    (armed && !load && !kick && cnt != '0) |=> (cnt == $past(cnt) - WD_W'(1)));
  // R7: expiry disarms the watchdog
  a_r7_disarm: assert property (@(posedge clk) disable iff (rst)
    expire |=> !armed);
endmodule

// File: rtl/rcfg_ctrl.sv
module rcfg_ctrl #(
  parameter int CLK_HZ  = 25_000_000,
  parameter int BOOT_W  = 23,
  parameter int WD_W    = 29,
  parameter int WD_HI_W = 12,
  localparam int BYTE_W = BOOT_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wb_cyc,
  input  logic              wb_stb,
  input  logic              wb_we,
  input  logic [1:0]        wb_adr,
  input  logic [31:0]       wb_dat_w,
  output logic [31:0]       wb_dat_r,
  output logic              wb_ack,
  input  logic              wd_kick,
  output logic              reconf_req,
  output logic [BYTE_W-1:0] reconf_addr
);
  if (CLK_HZ >= 40_000_000) begin : g_clk_too_fast
    $error("rcfg_ctrl: controller clock must be below 40 MHz");
  end

  logic wr_boot, wr_wd, wr_en, wr_ctl, any_wr, rd_stb;
  logic load, expire, pend_en;
  logic [WD_HI_W-1:0] pend_wd;

  rcfg_wb_port u_port (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_ack(wb_ack), .wr_boot(wr_boot), .wr_wd(wr_wd),
    .wr_en(wr_en), .wr_ctl(wr_ctl), .any_wr(any_wr), .rd_stb(rd_stb)
  );

  rcfg_regs #(.BOOT_W(BOOT_W), .WD_HI_W(WD_HI_W)) u_regs (
    .clk(clk), .rst(rst), .wr_boot(wr_boot), .wr_wd(wr_wd), .wr_en(wr_en),
    .wr_ctl(wr_ctl), .rd_stb(rd_stb), .rd_sel(wb_adr), .wdata(wb_dat_w),
    .expire(expire), .load(load), .pend_wd(pend_wd), .pend_en(pend_en),
    .rdata(wb_dat_r), .reconf_req(reconf_req), .reconf_addr(reconf_addr)
  );

  rcfg_wdog #(.WD_W(WD_W), .WD_HI_W(WD_HI_W)) u_wdog (
    .clk(clk), .rst(rst), .load(load), .en(pend_en), .start_hi(pend_wd),
    .kick(wd_kick | any_wr), .expire(expire)
  );
endmodule

// File: tb/sim_rcfg_ctrl.sv
module sim_rcfg_ctrl;
  localparam int CLK_NS  = 50;
  localparam int BOOT_W  = 23;
  localparam int WD_W    = 8;
  localparam int WD_HI_W = 4;
  localparam int LO      = WD_W - WD_HI_W;

  logic clk = 1'b0, rst = 1'b1;
  logic wb_cyc = 0, wb_stb = 0, wb_we = 0, wd_kick = 0;
  logic [1:0]  wb_adr = 0;
  logic [31:0] wb_dat_w = 0, wb_dat_r;
  logic wb_ack, reconf_req;
  logic [BOOT_W+1:0] reconf_addr;

  int errors = 0, checks = 0;
  bit done = 0;
  logic req1, req2;
  logic [31:0] addr1, rd;

  always #(CLK_NS/2) clk = ~clk;

  rcfg_ctrl #(.CLK_HZ(20_000_000), .BOOT_W(BOOT_W), .WD_W(WD_W), .WD_HI_W(WD_HI_W)) u0 (
    .clk(clk), .rst(rst), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_we(wb_we),
    .wb_adr(wb_adr), .wb_dat_w(wb_dat_w), .wb_dat_r(wb_dat_r), .wb_ack(wb_ack),
    .wd_kick(wd_kick), .reconf_req(reconf_req), .reconf_addr(reconf_addr));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input logic we, input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    chk("R2 ack idle", 32'(wb_ack), 0);
    wb_cyc = 1; wb_stb = 1; wb_we = we; wb_adr = a; wb_dat_w = d;
    @(negedge clk);
    chk("R2 ack after strobe", 32'(wb_ack), 1);
    rd = wb_dat_r; req1 = reconf_req; addr1 = 32'(reconf_addr);
    wb_cyc = 0; wb_stb = 0;
    @(negedge clk);
    chk("R2 ack one clock", 32'(wb_ack), 0);
    req2 = reconf_req;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d); xfer(1'b1, a, d); endtask
  task automatic rdchk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    xfer(1'b0, a, 32'h0); chk(tag, rd, exp);
  endtask
  task automatic set_rs(input logic [1:0] rs); wr(2'd3, 32'(rs) << 4); endtask

  task automatic wait_req(input int lim, output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!reconf_req && n < lim);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, s;
    logic [31:0] pv, v, b;
    repeat (4) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 req after reset", 32'(reconf_req), 0);
    rdchk("R1 boot", 2'd0, 0); rdchk("R1 wd", 2'd1, 0);
    rdchk("R1 en", 2'd2, 0);   rdchk("R1 ctl", 2'd3, 0);

    // R3 R4 R6 walking page sweep with bank moves
    pv = 0;
    for (int i = 0; i < BOOT_W; i++) begin
      v = 32'h1 << i;
      wr(2'd0, v);
      wr(2'd3, 32'h1);
      chk("R6 req with ack", 32'(req1), 1);
      chk("R6 req one clock", 32'(req2), 0);
      chk("R3 byte address", addr1, v << 2);
      rdchk("R4 current page", 2'd0, v);
      set_rs(2'b01); rdchk("R4 previous page", 2'd0, pv);
      set_rs(2'b11); rdchk("R4 pending page", 2'd0, v);
      set_rs(2'b00);
      pv = v;
    end
    wr(2'd0, 32'h20000); wr(2'd3, 32'h1);
    chk("R3 user page address", addr1, 32'h80000);

    // R4 reserved source and control readback
    set_rs(2'b10);
    rdchk("R4 reserved reads zero", 2'd0, 0);
    rdchk("R4 ctl code", 2'd3, 32'h20);
    set_rs(2'b11); rdchk("R4 ctl code 11", 2'd3, 32'h30);

    // R5 writes ignored unless source is 00
    set_rs(2'b00); wr(2'd1, 7);
    set_rs(2'b11); wr(2'd0, 32'h1234); wr(2'd1, 5);
    rdchk("R5 page write ignored", 2'd0, 32'h20000);
    rdchk("R5 wd write ignored", 2'd1, 7);
    // R6 go with a non-zero source code, bit 0 reads zero
    wr(2'd3, 32'h31);
    chk("R6 go under source 11", 32'(req1), 1);
    rdchk("R6 go bit reads zero", 2'd3, 32'h30);
    set_rs(2'b00); wr(2'd1, 0);

    // R7 watchdog sweep over every non-zero field value
    for (int f = 1; f < (1 << WD_HI_W); f++) begin
      s = f << LO; b = 32'(f * 32'h111);
      wr(2'd1, 32'(f)); wr(2'd2, 1); wr(2'd0, b); wr(2'd3, 1);
      chk("R7 launch address", addr1, b << 2);
      wait_req(s + 20, n);
      chk("R7 fallback timing", 32'(n), 32'(s));
      chk("R7 fallback address", 32'(reconf_addr), 0);
      rdchk("R7 current page zero", 2'd0, 0);
      rdchk("R7 current enable zero", 2'd2, 0);
      set_rs(2'b01);
      rdchk("R7 previous page", 2'd0, b);
      rdchk("R7 previous enable", 2'd2, 1);
      set_rs(2'b11); rdchk("R7 pending wd", 2'd1, 32'(f));
      set_rs(2'b00);
    end

    // R8 enable alone never arms
    wr(2'd2, 1);
    wait_req(300, n);
    chk("R8 no request without launch", 32'(reconf_req), 0);

    // R9 kick reload
    wr(2'd1, 3); wr(2'd3, 1);
    s = 3 << LO;
    wait_req(20, n);
    chk("R9 quiet before kick", 32'(reconf_req), 0);
    @(negedge clk); wd_kick = 1;
    @(negedge clk); wd_kick = 0;
    chk("R9 no request at kick", 32'(reconf_req), 0);
    wait_req(s + 20, n);
    chk("R9 fallback after kick", 32'(n), 32'(s + 1));

    // R9 write reload, R8 clearing pending enable keeps the armed watchdog
    wr(2'd1, 2); wr(2'd3, 1);
    s = 2 << LO;
    wait_req(10, n);
    chk("R8 quiet before write", 32'(reconf_req), 0);
    wr(2'd2, 0);
    wait_req(s + 20, n);
    chk("R9 fallback after write", 32'(n), 32'(s));

    // R8 launch with enable clear never falls back
    wr(2'd3, 1);
    chk("R8 launch request", 32'(req1), 1);
    wait_req(300, n);
    chk("R8 no fallback when disabled", 32'(reconf_req), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule